// File: doc/BRIEF.md
# Multichannel Scan Timing Sequencer

This block sets the timing of conversions for a multiplexed analog acquisition front end. An asynchronous sample-clock input passes through a synchronizer and an edge detector. Each rising edge that arrives while the block is idle starts one scan. The scan first waits a programmable number of fast timebase cycles. It then issues one single-cycle convert strobe per channel in the scan list. Consecutive strobes are a programmable number of timebase cycles apart. A channel index moves forward alongside the strobes.

The start delay is counted on the fast clock, not in convert periods, so a short hold-off adds only a few nanoseconds to each scan. A sample edge that arrives before a scan has finished is not queued. It is dropped, and a sticky overrun flag records it until software clears the flag. The channel count, delay and convert spacing are captured when a scan starts. A host can therefore change them at any time without disturbing a scan that is already running.

Top module: `scan_timing_seq`

## Requirements
- R1: After reset is released, conv_stb, end_of_scan, busy, drop_flag and chan_idx are all 0.
- R2: A rising edge of smp_in that is first sampled high at clock edge k is detected at edge k+2. If the block is idle at that edge and the channel count is nonzero, a scan starts there and busy is high from that edge on.
- R3: The first convert strobe is asserted at edge k+2+D, where D is the delay count, counted in timebase cycles. With D = 0 the first strobe appears in the cycle right after the detecting edge.
- R4: A scan issues exactly N convert strobes, where N is the channel count. Each strobe is one cycle wide, and consecutive strobes are V cycles apart, where V is the convert divisor. A divisor of 0 behaves as 1.
- R5: chan_idx is 0 at scan start and reads k−1 during the k-th strobe. It increments in the cycle after each strobe and returns to 0 after the last strobe.
- R6: end_of_scan is high for exactly the cycle of the last strobe of a scan.
- R7: busy stays high through the cycle of the last strobe and is low in the cycle after it.
- R8: A sample edge detected while busy is high starts no scan, leaves the running strobe schedule unchanged, and sets drop_flag at that edge.
- R9: drop_flag stays set until ovr_clr is sampled high. If a drop and a clear happen at the same edge, the drop wins.
- R10: The channel count, delay and divisor are captured at scan start. Changes to them during a scan have no effect on that scan.
- R11: With a channel count of 0, sample edges start no scan and do not set drop_flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master timebase |
| rst | input | 1 | Synchronous active-high reset |
| smp_in | input | 1 | Asynchronous sample-clock pulse |
| cfg_nchan | input | CH_W (5) | Channels per scan; 0 disables scanning |
| cfg_delay | input | DLY_W (4) | Start delay in timebase cycles (typically 3) |
| cfg_div | input | DIV_W (12) | Cycles between convert strobes |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| conv_stb | output | 1 | One-cycle convert strobe |
| chan_idx | output | CH_W (5) | Channel being converted |
| busy | output | 1 | Scan in progress |
| end_of_scan | output | 1 | High on the last strobe of a scan |
| drop_flag | output | 1 | Sticky flag: a sample edge was ignored |

## Verification
The scan is driven with several settings. A long scan with delay 3 and spacing 4 checks the start offset and the strobe spacing. A single-channel scan with no delay shows that the delay and end-of-scan logic work when start and finish coincide. A zero divisor shows its fallback to back-to-back strobes. A sample pulse train faster than the scan length makes the bench tell dropped edges apart from accepted ones, including an edge that lands on the last-strobe cycle. Mid-scan configuration writes and a zero channel count show that captured settings are used and that the disabled case stays silent.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WRAP = 2'd2
  } scan_st_e;
endpackage

// File: rtl/scan_edge_sync.sv
module scan_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh[0] <= async_in;
      prev  <= sh[STAGES-1];
    end
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) sh[g] <= 1'b0;
        else     sh[g] <= sh[g-1];
      end
    end
  endgenerate

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
#(
  parameter int CH_W  = 5,
  parameter int DLY_W = 4,
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [CH_W-1:0]  nchan,
  input  logic [DLY_W-1:0] dly,
  input  logic [DIV_W-1:0] div,
  output logic             stb,
  output logic             eos,
  output logic [CH_W-1:0]  idx,
  output logic             active
);
  localparam int TMR_W = (DLY_W > DIV_W) ? DLY_W : DIV_W;

  scan_st_e         state;
  logic [TMR_W-1:0] timer;
  logic [CH_W-1:0]  fired;
  logic [CH_W-1:0]  n_lat;
  logic [DIV_W-1:0] div_lat;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div == '0) ? DIV_W'(1) : div;
  assign active  = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      timer   <= '0;
      fired   <= '0;
      n_lat   <= '0;
      div_lat <= DIV_W'(1);
      stb     <= 1'b0;
      eos     <= 1'b0;
      idx     <= '0;
    end else begin
      stb <= 1'b0;
      eos <= 1'b0;
      if (stb) idx <= eos ? '0 : idx + 1'b1;
      case (state)
        ST_IDLE: begin
          if (start_req && nchan != '0) begin
            n_lat   <= nchan;
            div_lat <= div_eff;
            idx     <= '0;
            if (dly == '0) begin
              stb   <= 1'b1;
              eos   <= (nchan == CH_W'(1));
              fired <= CH_W'(1);
              timer <= TMR_W'(div_eff);
              state <= (nchan == CH_W'(1)) ? ST_WRAP : ST_RUN;
            end else begin
              fired <= '0;
              timer <= TMR_W'(dly);
              state <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          if (timer <= TMR_W'(1)) begin
            stb   <= 1'b1;
            eos   <= (fired == n_lat - 1'b1);
            fired <= fired + 1'b1;
            timer <= TMR_W'(div_lat);
            if (fired == n_lat - 1'b1) state <= ST_WRAP;
          end else begin
            timer <= timer - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scan_drop.sv
module scan_drop (
  input  logic clk,
  input  logic rst,
  input  logic edge_seen,
  input  logic active,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)                      flag <= 1'b0;
    else if (edge_seen && active) flag <= 1'b1;
    else if (clr)                 flag <= 1'b0;
  end
endmodule

// File: rtl/scan_timing_seq.sv
module scan_timing_seq #(
  parameter int CH_W        = 5,
  parameter int DLY_W       = 4,
  parameter int DIV_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_in,
  input  logic [CH_W-1:0]  cfg_nchan,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic             ovr_clr,
  output logic             conv_stb,
  output logic [CH_W-1:0]  chan_idx,
  output logic             busy,
  output logic             end_of_scan,
  output logic             drop_flag
);
  logic rise;
  logic active;

  scan_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (smp_in),
    .rise     (rise)
  );

  scan_ctrl #(.CH_W(CH_W), .DLY_W(DLY_W), .DIV_W(DIV_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start_req (rise),
    .nchan     (cfg_nchan),
    .dly       (cfg_delay),
    .div       (cfg_div),
    .stb       (conv_stb),
    .eos       (end_of_scan),
    .idx       (chan_idx),
    .active    (active)
  );

  scan_drop u_drop (
    .clk       (clk),
    .rst       (rst),
    .edge_seen (rise),
    .active    (active),
    .clr       (ovr_clr),
    .flag      (drop_flag)
  );

  assign busy = active;
endmodule

// File: rtl/scan_timing_seq_chk.sv
module scan_timing_seq_chk #(
  parameter int CH_W = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            ovr_clr,
  input logic            conv_stb,
  input logic [CH_W-1:0] chan_idx,
  input logic            busy,
  input logic            end_of_scan,
  input logic            drop_flag
);
  AST_EOS_WITH_STB: assert property (@(posedge clk) disable iff (rst)
    end_of_scan |-> conv_stb); // R6
  AST_EOS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    end_of_scan |=> !end_of_scan); // R6
  AST_STB_BUSY: assert property (@(posedge clk) disable iff (rst)
    conv_stb |-> busy); // R7
  AST_IDLE_AFTER_EOS: assert property (@(posedge clk) disable iff (rst)
    end_of_scan |=> !busy); // R7
  AST_IDX_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> chan_idx == '0); // R5
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
    end_of_scan |=> chan_idx == '0); // R5
  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(drop_flag) |-> $past(busy)); // R8
  AST_DROP_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(drop_flag) |-> $past(ovr_clr)); // R9
endmodule

bind scan_timing_seq scan_timing_seq_chk #(.CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ovr_clr     (ovr_clr),
  .conv_stb    (conv_stb),
  .chan_idx    (chan_idx),
  .busy        (busy),
  .end_of_scan (end_of_scan),
  .drop_flag   (drop_flag)
);

// File: tb/scan_timing_seq_tb.sv
`timescale 1ns/1ps
module scan_timing_seq_tb;
  localparam int CH_W = 5, DLY_W = 4, DIV_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_in = 1'b0;
  logic [CH_W-1:0]  cfg_nchan = 5'd8;
  logic [DLY_W-1:0] cfg_delay = 4'd3;
  logic [DIV_W-1:0] cfg_div = 12'd4;
  logic ovr_clr = 1'b0;
  logic conv_stb, busy, end_of_scan, drop_flag;
  logic [CH_W-1:0] chan_idx;

  int checks = 0, fails = 0;
  int stb_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  scan_timing_seq u_dut (
    .clk(clk), .rst(rst), .smp_in(smp_in), .cfg_nchan(cfg_nchan),
    .cfg_delay(cfg_delay), .cfg_div(cfg_div), .ovr_clr(ovr_clr),
    .conv_stb(conv_stb), .chan_idx(chan_idx), .busy(busy),
    .end_of_scan(end_of_scan), .drop_flag(drop_flag)
  );

  // behavioural reference
  bit m_s1, m_s2, m_prev, m_stb, m_eos, m_busy, m_drop;
  int m_idx, m_end, m_n, m_fired;
  longint cyc = 0;
  longint sched[$];

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    bit e, was_busy, pstb, peos;
    int dv;
    longint first;
    if (rst) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_stb = 0; m_eos = 0;
      m_busy = 0; m_drop = 0; m_idx = 0; m_end = 0; m_n = 0; m_fired = 0;
      sched.delete();
    end else begin
      e = m_s2 & ~m_prev;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = smp_in;
      pstb = m_stb; peos = m_eos;
      m_stb = 0; m_eos = 0;
      if (pstb) m_idx = peos ? 0 : m_idx + 1;
      was_busy = m_busy;
      if (e && was_busy) m_drop = 1;
      else if (ovr_clr) m_drop = 0;
      if (was_busy && cyc == m_end) m_busy = 0;
      if (e && !was_busy && cfg_nchan != 0) begin
        dv = (cfg_div == 0) ? 1 : int'(cfg_div);
        first = cyc + cfg_delay;
        m_n = cfg_nchan;
        for (int i = 0; i < m_n; i++) sched.push_back(first + i * dv);
        m_end = int'(first + (m_n - 1) * dv + 1);
        m_busy = 1; m_idx = 0; m_fired = 0;
      end
      if (sched.size() > 0 && sched[0] == cyc) begin
        void'(sched.pop_front());
        m_stb = 1; m_fired++;
        m_eos = (m_fired == m_n);
      end
    end
    cyc++;
    #1;
    if (!rst) begin
      chk("R3/R4", "conv_stb", conv_stb, m_stb);
      chk("R6", "end_of_scan", end_of_scan, m_eos);
      chk("R2/R7", "busy", busy, m_busy);
      chk("R5", "chan_idx", chan_idx, m_idx);
      chk("R8/R9", "drop_flag", drop_flag, m_drop);
      if (conv_stb) stb_cnt++;
    end
  end

  task automatic pulse();
    @(negedge clk) smp_in = 1'b1;
    repeat (2) @(negedge clk);
    smp_in = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "conv_stb", conv_stb, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "drop_flag", drop_flag, 0);
    chk("R1", "chan_idx", chan_idx, 0);
    chk("R1", "end_of_scan", end_of_scan, 0);

    // R3 R4: 8 channels, delay 3, spacing 4
    stb_cnt = 0;
    pulse(); idle(60);
    chk("R4", "strobes per scan", stb_cnt, 8);

    // R3 zero delay single channel
    cfg_nchan = 1; cfg_delay = 0; cfg_div = 1;
    stb_cnt = 0; pulse(); idle(10);
    chk("R3", "single strobe", stb_cnt, 1);

    // R4 divisor 0 behaves as 1
    cfg_nchan = 4; cfg_delay = 2; cfg_div = 0;
    stb_cnt = 0; pulse(); idle(15);
    chk("R4", "div0 strobes", stb_cnt, 4);

    // R10 config change mid-scan
    cfg_nchan = 6; cfg_delay = 3; cfg_div = 3;
    stb_cnt = 0; pulse(); idle(5);
    cfg_nchan = 2; cfg_div = 9; cfg_delay = 1;
    idle(40);
    chk("R10", "latched channel count", stb_cnt, 6);

    // R8 R9: overlapping sample edges
    cfg_nchan = 8; cfg_delay = 3; cfg_div = 5;
    pulse(); idle(8); pulse(); idle(5);
    chk("R8", "drop set", drop_flag, 1);
    idle(50);
    chk("R9", "drop sticky", drop_flag, 1);
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    chk("R9", "drop cleared", drop_flag, 0);

    // fast sample train: many drops plus edges near scan end
    cfg_nchan = 3; cfg_delay = 1; cfg_div = 2;
    for (int i = 0; i < 12; i++) begin
      pulse(); idle(i % 5);
    end
    idle(30);

    // R11 zero channels: nothing happens
    @(negedge clk) ovr_clr = 1'b1;
    @(negedge clk) ovr_clr = 1'b0;
    cfg_nchan = 0;
    stb_cnt = 0; pulse(); idle(10); pulse(); idle(10);
    chk("R11", "no strobes", stb_cnt, 0);
    chk("R11", "no drop", drop_flag, 0);
    chk("R11", "not busy", busy, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule